// File: doc/BRIEF.md
# Load Unit with Pointer Addressing Modes

This block carries out memory loads for a register-based processor core. Each request gives a base pointer value, a displacement taken either from a register or from a short unsigned constant, one of seven pointer modes and an access size. The block forms the effective byte address and the updated pointer value. It fetches the aligned 64-bit memory word that holds the access and pulls out the addressed little-endian element. Byte and halfword results are sign-extended to register width. A doubleword result fills an even/odd register pair.

The block is a two-stage pipeline. On the clock edge that takes a request, it issues a read strobe with a doubleword-aligned address. The memory answers on the next edge, and on that same edge the result, the destination register numbers, the misalignment flag and any pointer write-back become valid. An address that is not a multiple of the access size is flagged. The data still comes from the naturally aligned element that holds that address.

Top module: `ldu_load_unit`

## Requirements
- R1: Addresses are 32-bit byte addresses. One edge after a request, `mem_rd` is high and `mem_addr` is the effective address with its three low bits cleared. One edge after that, `res_valid` is high for exactly one cycle.
- R2: Memory data is little endian: the byte at the lowest address is the least significant. With bytes 01,02,03,04 at addresses 4 to 7, a word load from address 4 returns 0x04030201.
- R3: `acc_size` encodes 0 = byte, 1 = halfword, 2 = word, 3 = doubleword. Byte and halfword results are sign-extended to 32 bits in `res_lo`.
- R4: A doubleword load returns the low word in `res_lo`, written to the even register `{dst_idx[4:1],0}`, and the high word in `res_hi`, written to the odd register `{dst_idx[4:1],1}` with `res_hi_en` high. Every other size writes `res_lo` to `dst_idx`, with `res_hi_en` low and `res_hi` zero.
- R5: `addr_mode` encodes 0 = plain pointer, 1 = pointer plus offset, 2 = pointer minus offset, 3 = pre-increment, 4 = pre-decrement, 5 = post-increment, 6 = post-decrement, 7 = treated as plain pointer. Modes 1 to 4 access at the offset address. Modes 0, 5, 6 and 7 access at the unmodified base.
- R6: The displacement counts elements, so the offset is the displacement multiplied by 1, 2, 4 or 8 according to the access size. The sum or difference wraps modulo 2^32.
- R7: When `disp_is_imm` is 1, the displacement is the 5-bit `disp_imm` zero-extended. Otherwise it is the 32-bit `disp_reg`.
- R8: `wb_en` is high, with `wb_value` set to base plus or minus the scaled offset and `wb_idx` set to `ptr_idx`, only for modes 3 to 6. Modes 0, 1, 2 and 7 leave `wb_en` low.
- R9: `res_misalign` is high when the effective address is not a multiple of the access size in bytes. The data then comes from the element at the address rounded down to that size.
- R10: After reset, `mem_rd`, `res_valid` and `wb_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Load request this cycle |
| base_val | input | 32 | Pointer register value |
| disp_reg | input | 32 | Register displacement |
| disp_imm | input | 5 | Unsigned constant displacement |
| disp_is_imm | input | 1 | Select constant displacement |
| addr_mode | input | 3 | Pointer mode |
| acc_size | input | 2 | Access size |
| dst_idx | input | 5 | Destination register number |
| ptr_idx | input | 5 | Pointer register number |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Doubleword-aligned read address |
| mem_rdata | input | 64 | Read data, valid one edge after `mem_rd` |
| res_valid | output | 1 | Result valid |
| res_lo | output | 32 | Low / only result word |
| res_hi | output | 32 | High word of a doubleword |
| res_lo_idx | output | 5 | Register for `res_lo` |
| res_hi_idx | output | 5 | Register for `res_hi` |
| res_hi_en | output | 1 | Write `res_hi` |
| res_misalign | output | 1 | Effective address misaligned for the size |
| wb_en | output | 1 | Pointer write-back enable |
| wb_idx | output | 5 | Pointer register to update |
| wb_value | output | 32 | Updated pointer value |

## Verification
A wrong mode decode or a wrong displacement scale shows up at `mem_addr` one edge after the request, before any data returns. Wrong lane selection, extension or pair steering shows up in the result fields on the following edge. A pointer update leaking into the offset modes, or missing from the modifying modes, shows up as `wb_en` or `wb_value` in that same result cycle. Because each request produces results within two edges, every fault is visible in the transaction that caused it.

// File: rtl/ldu_pkg.sv
package ldu_pkg;

   typedef enum logic [2:0] {
      AM_PTR     = 3'd0,
      AM_PLUS    = 3'd1,
      AM_MINUS   = 3'd2,
      AM_PREINC  = 3'd3,
      AM_PREDEC  = 3'd4,
      AM_POSTINC = 3'd5,
      AM_POSTDEC = 3'd6,
      AM_RSVD    = 3'd7
   } amode_e;

   typedef enum logic [1:0] {
      SZ_B = 2'd0,
      SZ_H = 2'd1,
      SZ_W = 2'd2,
      SZ_D = 2'd3
   } asize_e;

endpackage

// File: rtl/ldu_agen.sv
module ldu_agen
   import ldu_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IMM_W  = 5
) (
   input  logic [ADDR_W-1:0] base_val,
   input  logic [ADDR_W-1:0] disp_reg,
   input  logic [IMM_W-1:0]  disp_imm,
   input  logic              disp_is_imm,
   input  amode_e            mode,
   input  asize_e            size,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [ADDR_W-1:0] new_base,
   output logic              wb_req,
   output logic              misalign
);

   logic [ADDR_W-1:0] raw_disp;
   logic [ADDR_W-1:0] scaled;
   logic [ADDR_W-1:0] up_addr;
   logic [ADDR_W-1:0] dn_addr;
   logic [ADDR_W-1:0] size_mask;

   always_comb begin
      raw_disp = disp_is_imm ? ADDR_W'(disp_imm) : disp_reg;
      scaled   = raw_disp << size;
      up_addr  = base_val + scaled;
      dn_addr  = base_val - scaled;
   end

   always_comb begin
      eff_addr = base_val;
      new_base = base_val;
      wb_req   = 1'b0;
      unique case (mode)
         AM_PLUS:    eff_addr = up_addr;
         AM_MINUS:   eff_addr = dn_addr;
         AM_PREINC: begin
            eff_addr = up_addr;
            new_base = up_addr;
            wb_req   = 1'b1;
         end
         AM_PREDEC: begin
            eff_addr = dn_addr;
            new_base = dn_addr;
            wb_req   = 1'b1;
         end
         AM_POSTINC: begin
            new_base = up_addr;
            wb_req   = 1'b1;
         end
         AM_POSTDEC: begin
            new_base = dn_addr;
            wb_req   = 1'b1;
         end
         default:    eff_addr = base_val;
      endcase
   end

   always_comb begin
      size_mask = (ADDR_W'(1) << size) - ADDR_W'(1);
      misalign  = |(eff_addr & size_mask);
   end

endmodule

// File: rtl/ldu_lane_extract.sv
module ldu_lane_extract
   import ldu_pkg::*;
#(
   parameter int REG_W    = 32,
   parameter bit SIGN_EXT = 1'b1,
   localparam int MEM_W   = 2 * REG_W,
   localparam int LANE_W  = $clog2(MEM_W / 8)
) (
   input  logic [MEM_W-1:0]  rdata,
   input  logic [LANE_W-1:0] lane,
   input  asize_e            size,
   output logic [REG_W-1:0]  lo_word,
   output logic [REG_W-1:0]  hi_word
);

   logic [MEM_W-1:0] shifted;
   logic [7:0]       byte_v;
   logic [15:0]      half_v;
   logic [REG_W-1:0] byte_x;
   logic [REG_W-1:0] half_x;

   always_comb begin
      shifted = rdata >> {lane, 3'b000};
      byte_v  = shifted[7:0];
      half_v  = shifted[15:0];
   end

   generate
      if (SIGN_EXT) begin : g_sext
         always_comb begin
            byte_x = {{(REG_W-8){byte_v[7]}}, byte_v};
            half_x = {{(REG_W-16){half_v[15]}}, half_v};
         end
      end else begin : g_zext
         always_comb begin
            byte_x = REG_W'(byte_v);
            half_x = REG_W'(half_v);
         end
      end
   endgenerate

   always_comb begin
      hi_word = '0;
      unique case (size)
         SZ_B: lo_word = byte_x;
         SZ_H: lo_word = half_x;
         SZ_W: lo_word = shifted[REG_W-1:0];
         default: begin
            lo_word = rdata[REG_W-1:0];
            hi_word = rdata[MEM_W-1:REG_W];
         end
      endcase
   end

endmodule

// File: rtl/ldu_load_unit.sv
module ldu_load_unit
   import ldu_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int REG_W    = 32,
   parameter int IMM_W    = 5,
   parameter int IDX_W    = 5,
   parameter bit SIGN_EXT = 1'b1,
   localparam int MEM_W   = 2 * REG_W,
   localparam int LANE_W  = $clog2(MEM_W / 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [ADDR_W-1:0] disp_reg,
   input  logic [IMM_W-1:0]  disp_imm,
   input  logic              disp_is_imm,
   input  logic [2:0]        addr_mode,
   input  logic [1:0]        acc_size,
   input  logic [IDX_W-1:0]  dst_idx,
   input  logic [IDX_W-1:0]  ptr_idx,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [MEM_W-1:0]  mem_rdata,
   output logic              res_valid,
   output logic [REG_W-1:0]  res_lo,
   output logic [REG_W-1:0]  res_hi,
   output logic [IDX_W-1:0]  res_lo_idx,
   output logic [IDX_W-1:0]  res_hi_idx,
   output logic              res_hi_en,
   output logic              res_misalign,
   output logic              wb_en,
   output logic [IDX_W-1:0]  wb_idx,
   output logic [ADDR_W-1:0] wb_value
);

   // elaboration-time parameter checks
   if (REG_W != 32) begin : g_bad_reg_w
      $error("ldu_load_unit: REG_W must be 32");
   end
   if (ADDR_W < LANE_W + 1) begin : g_bad_addr_w
      $error("ldu_load_unit: ADDR_W too small");
   end
   if (IDX_W < 2) begin : g_bad_idx_w
      $error("ldu_load_unit: IDX_W must allow register pairs");
   end

   // address generation
   logic [ADDR_W-1:0] ea;
   logic [ADDR_W-1:0] nb;
   logic              wb_req;
   logic              mis;

   ldu_agen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_agen (
      .base_val    (base_val),
      .disp_reg    (disp_reg),
      .disp_imm    (disp_imm),
      .disp_is_imm (disp_is_imm),
      .mode        (amode_e'(addr_mode)),
      .size        (asize_e'(acc_size)),
      .eff_addr    (ea),
      .new_base    (nb),
      .wb_req      (wb_req),
      .misalign    (mis)
   );

   logic [LANE_W:0]   size_mask;
   logic [LANE_W-1:0] lane_d;

   always_comb begin
      size_mask = (LANE_W+1)'(((LANE_W+1)'(1) << acc_size) - (LANE_W+1)'(1));
      lane_d    = ea[LANE_W-1:0] & ~size_mask[LANE_W-1:0];
   end

   // stage 1: fetch issue
   logic [LANE_W-1:0] s1_lane;
   asize_e            s1_size;
   logic [IDX_W-1:0]  s1_dst;
   logic [IDX_W-1:0]  s1_ptr;
   logic [ADDR_W-1:0] s1_nb;
   logic              s1_wb;
   logic              s1_mis;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_rd   <= 1'b0;
         mem_addr <= '0;
         s1_lane  <= '0;
         s1_size  <= SZ_B;
         s1_dst   <= '0;
         s1_ptr   <= '0;
         s1_nb    <= '0;
         s1_wb    <= 1'b0;
         s1_mis   <= 1'b0;
      end else begin
         mem_rd <= req_valid;
         if (req_valid) begin
            mem_addr <= {ea[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
            s1_lane  <= lane_d;
            s1_size  <= asize_e'(acc_size);
            s1_dst   <= dst_idx;
            s1_ptr   <= ptr_idx;
            s1_nb    <= nb;
            s1_wb    <= wb_req;
            s1_mis   <= mis;
         end
      end
   end

   // stage 2: result
   logic [LANE_W-1:0] s2_lane;
   asize_e            s2_size;
   logic [IDX_W-1:0]  s2_dst;
   logic              s2_wb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid    <= 1'b0;
         s2_lane      <= '0;
         s2_size      <= SZ_B;
         s2_dst       <= '0;
         s2_wb        <= 1'b0;
         res_misalign <= 1'b0;
         wb_idx       <= '0;
         wb_value     <= '0;
      end else begin
         res_valid <= mem_rd;
         s2_wb     <= mem_rd & s1_wb;
         if (mem_rd) begin
            s2_lane      <= s1_lane;
            s2_size      <= s1_size;
            s2_dst       <= s1_dst;
            res_misalign <= s1_mis;
            wb_idx       <= s1_ptr;
            wb_value     <= s1_nb;
         end
      end
   end

   ldu_lane_extract #(.REG_W(REG_W), .SIGN_EXT(SIGN_EXT)) u_extract (
      .rdata   (mem_rdata),
      .lane    (s2_lane),
      .size    (s2_size),
      .lo_word (res_lo),
      .hi_word (res_hi)
   );

   always_comb begin
      wb_en = s2_wb;
      if (s2_size == SZ_D) begin
         res_lo_idx = {s2_dst[IDX_W-1:1], 1'b0};
         res_hi_idx = {s2_dst[IDX_W-1:1], 1'b1};
         res_hi_en  = res_valid;
      end else begin
         res_lo_idx = s2_dst;
         res_hi_idx = s2_dst;
         res_hi_en  = 1'b0;
      end
   end

   // assertions
   assert_fetch_then_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> res_valid);

   assert_result_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !$past(req_valid, 2)) |=> !res_valid);

   assert_pair_even_odd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_hi_en) |-> (!res_lo_idx[0] && res_hi_idx == res_lo_idx + IDX_W'(1)));

   assert_byte_extension_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && s2_size == SZ_B && SIGN_EXT) |->
         ((&res_lo[REG_W-1:7]) || !(|res_lo[REG_W-1:7])));

   assert_wb_within_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> res_valid);

   assert_byte_never_misaligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && s2_size == SZ_B) |-> !res_misalign);

endmodule

// File: tb/ldu_load_unit_test.sv
`timescale 1ns/1ps
module ldu_load_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] base_val = '0;
   logic [31:0] disp_reg = '0;
   logic [4:0]  disp_imm = '0;
   logic        disp_is_imm = 1'b0;
   logic [2:0]  addr_mode = '0;
   logic [1:0]  acc_size = '0;
   logic [4:0]  dst_idx = '0;
   logic [4:0]  ptr_idx = '0;
   logic        mem_rd;
   logic [31:0] mem_addr;
   logic [63:0] mem_rdata = '0;
   logic        res_valid;
   logic [31:0] res_lo, res_hi;
   logic [4:0]  res_lo_idx, res_hi_idx;
   logic        res_hi_en, res_misalign;
   logic        wb_en;
   logic [4:0]  wb_idx;
   logic [31:0] wb_value;

   int n_checks = 0;
   int n_fail = 0;
   bit pattern_lin = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ldu_load_unit uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_val(base_val),
      .disp_reg(disp_reg), .disp_imm(disp_imm), .disp_is_imm(disp_is_imm),
      .addr_mode(addr_mode), .acc_size(acc_size), .dst_idx(dst_idx),
      .ptr_idx(ptr_idx), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .res_valid(res_valid), .res_lo(res_lo),
      .res_hi(res_hi), .res_lo_idx(res_lo_idx), .res_hi_idx(res_hi_idx),
      .res_hi_en(res_hi_en), .res_misalign(res_misalign), .wb_en(wb_en),
      .wb_idx(wb_idx), .wb_value(wb_value)
   );

   function automatic logic [7:0] byte_at(input logic [31:0] a);
      if (pattern_lin) return a[7:0] - 8'd3;
      return (a[7:0] * 8'd29) ^ a[15:8] ^ a[31:24] ^ 8'h5A;
   endfunction

   // memory model: registered read of an aligned doubleword
   always @(posedge clk) begin
      if (mem_rd) begin
         for (int k = 0; k < 8; k++)
            mem_rdata[k*8 +: 8] <= byte_at({mem_addr[31:3], 3'b000} + 32'(k));
      end
   end

   task automatic check(input string tag, input string field,
                        input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, field, got, exp);
      end
   endtask

   task automatic run_op(input string tag, input logic [31:0] b,
                         input logic [31:0] dr, input logic [4:0] di,
                         input bit use_imm, input logic [2:0] md,
                         input logic [1:0] sz, input logic [4:0] dst,
                         input logic [4:0] pidx);
      logic [31:0] disp, scaled, up, dn, ea, nbase, cont, elo, ehi;
      logic [4:0]  elo_idx;
      bit          ewb, emis;
      int          nbytes;
      disp   = use_imm ? {27'd0, di} : dr;
      nbytes = 1 << sz;
      scaled = disp * nbytes;
      up     = b + scaled;
      dn     = b - scaled;
      ea = b; nbase = b; ewb = 0;
      case (md)
         3'd1: ea = up;
         3'd2: ea = dn;
         3'd3: begin ea = up; nbase = up; ewb = 1; end
         3'd4: begin ea = dn; nbase = dn; ewb = 1; end
         3'd5: begin nbase = up; ewb = 1; end
         3'd6: begin nbase = dn; ewb = 1; end
         default: ;
      endcase
      emis = (ea % nbytes) != 0;
      cont = ea - (ea % nbytes);
      ehi  = '0;
      case (sz)
         2'd0: elo = {{24{byte_at(cont)[7]}}, byte_at(cont)};
         2'd1: elo = {{16{byte_at(cont+1)[7]}}, byte_at(cont+1), byte_at(cont)};
         2'd2: elo = {byte_at(cont+3), byte_at(cont+2), byte_at(cont+1), byte_at(cont)};
         default: begin
            elo = {byte_at(cont+3), byte_at(cont+2), byte_at(cont+1), byte_at(cont)};
            ehi = {byte_at(cont+7), byte_at(cont+6), byte_at(cont+5), byte_at(cont+4)};
         end
      endcase
      elo_idx = (sz == 2'd3) ? {dst[4:1], 1'b0} : dst;

      base_val = b; disp_reg = dr; disp_imm = di; disp_is_imm = use_imm;
      addr_mode = md; acc_size = sz; dst_idx = dst; ptr_idx = pidx;
      req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check(tag, "mem_rd", 32'(mem_rd), 32'd1);
      check(tag, "mem_addr", mem_addr, {ea[31:3], 3'b000});
      @(posedge clk);
      @(negedge clk);
      check(tag, "res_valid", 32'(res_valid), 32'd1);
      check(tag, "res_lo", res_lo, elo);
      check(tag, "res_hi", res_hi, ehi);
      check(tag, "res_hi_en", 32'(res_hi_en), 32'(sz == 2'd3));
      check(tag, "res_lo_idx", 32'(res_lo_idx), 32'(elo_idx));
      if (sz == 2'd3) check(tag, "res_hi_idx", 32'(res_hi_idx), 32'({dst[4:1], 1'b1}));
      check(tag, "misalign", 32'(res_misalign), 32'(emis));
      check(tag, "wb_en", 32'(wb_en), 32'(ewb));
      if (ewb) begin
         check(tag, "wb_value", wb_value, nbase);
         check(tag, "wb_idx", 32'(wb_idx), 32'(pidx));
      end
   endtask

   initial begin
      void'($urandom(32'd20250));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10: quiet after reset
      check("R10", "mem_rd", 32'(mem_rd), 32'd0);
      check("R10", "res_valid", 32'(res_valid), 32'd0);
      check("R10", "wb_en", 32'(wb_en), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      pattern_lin = 1'b1;
      // R2: word at address 4 is 0x04030201
      run_op("R2", 32'h4, 32'h0, 5'd0, 1'b1, 3'd0, 2'd2, 5'd7, 5'd5);
      check("R2", "word_value", res_lo, 32'h04030201);
      // R3: byte and halfword sign extension
      run_op("R3", 32'h85, 32'h0, 5'd0, 1'b1, 3'd0, 2'd0, 5'd3, 5'd1);
      check("R3", "byte_sext", res_lo, 32'hFFFFFF82);
      run_op("R3", 32'h84, 32'h0, 5'd0, 1'b1, 3'd0, 2'd1, 5'd3, 5'd1);
      check("R3", "half_sext", res_lo, 32'hFFFF8281);
      // R4: doubleword pair with odd destination number
      run_op("R4", 32'h8, 32'h0, 5'd0, 1'b1, 3'd0, 2'd3, 5'd7, 5'd5);
      check("R4", "dw_lo", res_lo, 32'h08070605);
      check("R4", "dw_hi", res_hi, 32'h0C0B0A09);
      pattern_lin = 1'b0;
      // R5 R6: every mode and size with a constant displacement
      for (int m = 0; m < 8; m++)
         for (int s = 0; s < 4; s++)
            run_op("R5", 32'h0000_1000, 32'h0, 5'd3, 1'b1, 3'(m), 2'(s), 5'd10, 5'd12);
      // R6: wrap-around of the scaled offset
      run_op("R6", 32'hFFFF_FFF8, 32'h0, 5'd2, 1'b1, 3'd3, 2'd3, 5'd2, 5'd4);
      check("R6", "wrap_wb", wb_value, 32'h0000_0008);
      // R7: register displacement versus constant
      run_op("R7", 32'h2000, 32'h0000_0100, 5'd1, 1'b0, 3'd1, 2'd2, 5'd1, 5'd2);
      check("R7", "reg_disp_addr", mem_addr, 32'h2400);
      run_op("R7", 32'h2000, 32'h0000_0100, 5'd31, 1'b1, 3'd2, 2'd1, 5'd1, 5'd2);
      // R8: offset modes leave the pointer alone, post-modify updates it
      run_op("R8", 32'h3000, 32'h0, 5'd4, 1'b1, 3'd1, 2'd2, 5'd1, 5'd9);
      run_op("R8", 32'h3000, 32'h0, 5'd4, 1'b1, 3'd5, 2'd2, 5'd1, 5'd9);
      check("R8", "post_wb", wb_value, 32'h3010);
      // R9: misaligned word and doubleword
      run_op("R9", 32'h3002, 32'h0, 5'd0, 1'b1, 3'd0, 2'd2, 5'd1, 5'd9);
      run_op("R9", 32'h300C, 32'h0, 5'd0, 1'b1, 3'd6, 2'd3, 5'd1, 5'd9);
      // R1: random mix
      for (int i = 0; i < 400; i++) begin
         logic [31:0] rb;
         logic [1:0]  rs;
         rb = $urandom;
         rs = 2'($urandom % 4);
         if (($urandom % 4) != 0) rb = rb & ~((32'd1 << rs) - 32'd1);
         run_op("R1", rb, (($urandom % 2) != 0) ? 32'($urandom % 64) : $urandom,
                5'($urandom), 1'($urandom), 3'($urandom % 8), rs,
                5'($urandom), 5'($urandom));
      end
      // R1: single-cycle result pulse
      @(negedge clk);
      check("R1", "res_valid_idle", 32'(res_valid), 32'd0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      for (int c = 0; c < 100000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

endmodule